// File: doc/BRIEF.md
# Serial Port with Enable-Driven Initialization

This block is an asynchronous serial port peripheral that a processor reaches through a small register bus. It contains a transmit path (holding buffer plus shift register) and a receive path (shift register plus holding buffer). It also has the receive error flags and two sticky interrupt request latches, one for transmit and one for receive. Bit timing comes from an external baud enable pulse. That pulse runs at an oversampling rate, so one serial bit lasts `OVS` enabled clock cycles.

The enable bits in the control word do more than gate each direction. They also initialize it. Clearing the transmit enable drops the frame in flight, empties the shifter, and zeroes both transmit flags. Clearing either the receive enable or the port-wide enable abandons any partial frame and zeroes the receive flags. Setting the transmit enable marks the transmitter as empty and idle and raises a transmit request at once. Software clears the requests through dedicated clear inputs.

Top module: `sio_unit`

## Requirements
- R1: After reset, the status word (address 2) reads 0, both interrupt requests are low, and `txd` is high.
- R2: A control write (address 1) that sets transmit enable (bit 4) while it was clear makes status bits 0 (tx buffer empty) and 1 (tx shift complete) read 1 and sets `txIrq`. This happens whatever the tx request source select (bit 1) holds.
- R3: Writing transmit enable to 0 clears status bits 0 and 1 on that write and returns `txd` to high within one further cycle. A frame or byte that was in progress or pending is never sent, even after transmit is enabled again.
- R4: A transmitted frame is a 0 start bit, then 8 data bits LSB first, then an even-parity bit when control bit 0 is set, then a 1 stop bit. Each bit lasts `OVS` baud enables.
- R5: With select bit 1 = 0, `txIrq` is set when the buffer byte moves into the shifter. With select bit 1 = 1, it is set only when the shifter finishes with the buffer empty.
- R6: A received frame sets status bit 2 (rx full), loads the byte read at address 0 and sets `rxIrq`. A read of address 0 with `rdEn` clears rx full.
- R7: A frame that completes while rx full is still set sets status bit 3 (overrun) and leaves the buffered byte unchanged.
- R8: A 0 stop bit sets status bit 4 (framing error). A parity bit that breaks even parity, when parity is enabled, sets status bit 5 (parity error).
- R9: Clearing receive enable (bit 5) or the port enable (bit 7) clears status bits 2 to 5 and discards a partially received frame.
- R10: Each request stays set until its clear input is pulsed. If a set event and the clear fall in the same cycle, the set wins.
- R11: A data write while transmit is disabled is ignored: nothing is sent and status bit 0 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe (a data read releases the rx buffer) |
| rdData | output | 8 | Combinational read data for `addr` |
| baudTick | input | 1 | Oversampling baud enable |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idle high |
| txIrqClr | input | 1 | Clears the transmit request |
| rxIrqClr | input | 1 | Clears the receive request |
| txIrq | output | 1 | Transmit interrupt request |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with `OVS` = 4 and holds `baudTick` high. Each bit therefore lasts four clocks, which keeps full frames, back-to-back frames and overrun inside a short run while still putting the receiver's mid-bit sample away from the edges. A loopback from `txd` to `rxd` exercises both directions together. Directly driven frames reach the framing and parity error cases and the partial frame cut off by a disable.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_W = 8;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int BIT_PAR   = 0;
  localparam int BIT_TXSEL = 1;
  localparam int BIT_TXEN  = 4;
  localparam int BIT_RXEN  = 5;
  localparam int BIT_SIOEN = 7;
  localparam logic [7:0] CTRL_MASK = 8'hB3;

  typedef struct packed {
    logic              txLoad;
    logic              txClear;
    logic              rxClear;
    logic              parityEn;
    logic [DATA_W-1:0] txByte;
  } ctl2dp_t;

  typedef struct packed {
    logic              txIdle;
    logic              txShiftDone;
    logic              rxDone;
    logic [DATA_W-1:0] rxByte;
    logic              rxFrameErr;
    logic              rxParErr;
  } dp2ctl_t;
endpackage

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    baudTick,
  input  logic    rxdIn,
  output logic    txdOut,
  input  ctl2dp_t cmd,
  output dp2ctl_t evt
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DATA_W);
  localparam int FRAME_P = DATA_W + 3;
  localparam logic [CW-1:0] TICK_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] TICK_MID  = CW'(OVS / 2 - 1);
  localparam logic [3:0] IDX_DATA_END = 4'(DATA_W);
  localparam logic [3:0] IDX_PAR      = 4'(DATA_W + 1);

  // transmit shifter
  logic                 txBusy;
  logic [CW-1:0]        txTick;
  logic [FRAME_P-1:0]   txSh;
  logic [3:0]           txLeft;
  logic                 txDoneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0; txTick <= '0; txSh <= '0; txLeft <= '0; txDoneQ <= 1'b0;
    end else if (cmd.txClear) begin
      txBusy <= 1'b0; txTick <= '0; txSh <= '0; txLeft <= '0; txDoneQ <= 1'b0;
    end else begin
      txDoneQ <= 1'b0;
      if (cmd.txLoad) begin
        txSh   <= {1'b1, (cmd.parityEn ? ^cmd.txByte : 1'b1), cmd.txByte, 1'b0};
        txLeft <= cmd.parityEn ? 4'(FRAME_P) : 4'(FRAME_P - 1);
        txBusy <= 1'b1;
        txTick <= '0;
      end else if (txBusy && baudTick) begin
        if (txTick == TICK_LAST) begin
          txTick <= '0;
          txSh   <= {1'b1, txSh[FRAME_P-1:1]};
          txLeft <= txLeft - 4'd1;
          if (txLeft == 4'd1) begin
            txBusy  <= 1'b0;
            txDoneQ <= 1'b1;
          end
        end else begin
          txTick <= txTick + CW'(1);
        end
      end
    end
  end

  assign txdOut          = txBusy ? txSh[0] : 1'b1;
  assign evt.txIdle      = ~txBusy;
  assign evt.txShiftDone = txDoneQ;

  // receive sampler
  logic              rxS1, rxS2;
  logic              rxBusy;
  logic [CW-1:0]     rxTick;
  logic [3:0]        rxIdx;
  logic [DATA_W-1:0] rxByteQ;
  logic              rxParQ, rxDoneQ, rxFrErrQ, rxParErrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxS1 <= 1'b1; rxS2 <= 1'b1;
    end else begin
      rxS1 <= rxdIn; rxS2 <= rxS1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBusy <= 1'b0; rxTick <= '0; rxIdx <= '0; rxByteQ <= '0; rxParQ <= 1'b0;
      rxDoneQ <= 1'b0; rxFrErrQ <= 1'b0; rxParErrQ <= 1'b0;
    end else if (cmd.rxClear) begin
      rxBusy <= 1'b0; rxTick <= '0; rxIdx <= '0; rxByteQ <= '0; rxParQ <= 1'b0;
      rxDoneQ <= 1'b0; rxFrErrQ <= 1'b0; rxParErrQ <= 1'b0;
    end else begin
      rxDoneQ <= 1'b0;
      if (baudTick) begin
        if (!rxBusy) begin
          if (!rxS2) begin
            rxBusy <= 1'b1; rxTick <= '0; rxIdx <= '0;
          end
        end else begin
          rxTick <= (rxTick == TICK_LAST) ? '0 : rxTick + CW'(1);
          if (rxTick == TICK_MID) begin
            if (rxIdx == 4'd0) begin
              if (rxS2) rxBusy <= 1'b0;
              else      rxIdx  <= 4'd1;
            end else if (rxIdx <= IDX_DATA_END) begin
              rxByteQ[IW'(rxIdx - 4'd1)] <= rxS2;
              rxIdx <= rxIdx + 4'd1;
            end else if (rxIdx == IDX_PAR && cmd.parityEn) begin
              rxParQ <= rxS2;
              rxIdx  <= rxIdx + 4'd1;
            end else begin
              rxDoneQ   <= 1'b1;
              rxFrErrQ  <= ~rxS2;
              rxParErrQ <= cmd.parityEn & (^rxByteQ ^ rxParQ);
              rxBusy    <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign evt.rxDone     = rxDoneQ;
  assign evt.rxByte     = rxByteQ;
  assign evt.rxFrameErr = rxFrErrQ;
  assign evt.rxParErr   = rxParErrQ;

  // R3
  tx_clear_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.txClear |=> txdOut);
  // R4
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txdOut);
  // R9
  rx_clear_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rxClear |=> !evt.rxDone);
endmodule

// File: rtl/sio_control.sv
module sio_control
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] addr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  output logic [7:0] rdData,
  input  logic       txIrqClr,
  input  logic       rxIrqClr,
  output logic       txIrq,
  output logic       rxIrq,
  output ctl2dp_t    cmd,
  input  dp2ctl_t    evt
);
  logic [7:0]        ctrlReg;
  logic [DATA_W-1:0] txBuf, rxBuf;
  logic txEmpty, txDone, rxFull, ovr, frErr, parErr, txIrqQ, rxIrqQ;

  logic ctrlWr, dataWr, dataRd, txOn, rxOn, txRise, txOffWr, rxOffWr, rxClrNow;
  logic txSetEv, rxSetEv, rxAccept;

  assign ctrlWr   = wrEn && addr == ADDR_CTRL;
  assign txOn     = ctrlReg[BIT_TXEN];
  assign rxOn     = ctrlReg[BIT_RXEN] & ctrlReg[BIT_SIOEN];
  assign dataWr   = wrEn && addr == ADDR_DATA && txOn;
  assign dataRd   = rdEn && addr == ADDR_DATA;
  assign txRise   = ctrlWr & wrData[BIT_TXEN] & ~txOn;
  assign txOffWr  = ctrlWr & ~wrData[BIT_TXEN];
  assign rxOffWr  = ctrlWr & ~(wrData[BIT_RXEN] & wrData[BIT_SIOEN]);
  assign rxClrNow = ~rxOn | rxOffWr;
  assign rxAccept = rxOn & evt.rxDone & (~rxFull | dataRd);

  assign cmd.txLoad   = txOn & ~txEmpty & evt.txIdle;
  assign cmd.txClear  = ~txOn;
  assign cmd.rxClear  = ~rxOn;
  assign cmd.parityEn = ctrlReg[BIT_PAR];
  assign cmd.txByte   = txBuf;

  assign txSetEv = txRise | (txOn & (ctrlReg[BIT_TXSEL] ? (evt.txShiftDone & txEmpty)
                                                       : cmd.txLoad));
  assign rxSetEv = rxAccept & ~rxClrNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0; txBuf <= '0; txEmpty <= 1'b0; txDone <= 1'b0;
    end else begin
      if (ctrlWr) ctrlReg <= wrData & CTRL_MASK;
      if (dataWr) txBuf <= wrData;
      if (txOffWr || (!txOn && !txRise)) begin
        txEmpty <= 1'b0; txDone <= 1'b0;
      end else if (txRise) begin
        txEmpty <= 1'b1; txDone <= 1'b1;
      end else begin
        if (dataWr)          txEmpty <= 1'b0;
        else if (cmd.txLoad) txEmpty <= 1'b1;
        if (cmd.txLoad)                      txDone <= 1'b0;
        else if (evt.txShiftDone && txEmpty) txDone <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf <= '0; rxFull <= 1'b0; ovr <= 1'b0; frErr <= 1'b0; parErr <= 1'b0;
    end else if (rxClrNow) begin
      rxFull <= 1'b0; ovr <= 1'b0; frErr <= 1'b0; parErr <= 1'b0;
    end else if (evt.rxDone) begin
      if (rxAccept) begin
        rxBuf  <= evt.rxByte;
        rxFull <= 1'b1;
        frErr  <= frErr | evt.rxFrameErr;
        parErr <= parErr | evt.rxParErr;
      end else begin
        ovr <= 1'b1;
      end
    end else if (dataRd) begin
      rxFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIrqQ <= 1'b0; rxIrqQ <= 1'b0;
    end else begin
      if (txSetEv)       txIrqQ <= 1'b1;
      else if (txIrqClr) txIrqQ <= 1'b0;
      if (rxSetEv)       rxIrqQ <= 1'b1;
      else if (rxIrqClr) rxIrqQ <= 1'b0;
    end
  end

  assign txIrq = txIrqQ;
  assign rxIrq = rxIrqQ;

  always_comb begin
    case (addr)
      ADDR_DATA: rdData = rxBuf;
      ADDR_CTRL: rdData = ctrlReg;
      ADDR_STAT: rdData = {2'b00, parErr, frErr, ovr, rxFull, txDone, txEmpty};
      default:   rdData = 8'h00;
    endcase
  end

  // R2
  tx_rise_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    txRise |=> txEmpty && txDone && txIrqQ);
  // R3
  tx_off_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    txOffWr |=> !txEmpty && !txDone);
  // R9
  rx_off_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxClrNow |=> !rxFull && !ovr && !frErr && !parErr);
  // R7
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxClrNow && evt.rxDone && rxFull && !dataRd) |=> ovr && $stable(rxBuf));
  // R10
  tx_irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txIrqQ && !txIrqClr) |=> txIrqQ);
  // R10
  rx_irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxIrqQ && !rxIrqClr) |=> rxIrqQ);
endmodule

// File: rtl/sio_unit.sv
module sio_unit
  import sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] addr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  output logic [7:0] rdData,
  input  logic       baudTick,
  input  logic       rxd,
  output logic       txd,
  input  logic       txIrqClr,
  input  logic       rxIrqClr,
  output logic       txIrq,
  output logic       rxIrq
);
  ctl2dp_t cmd;
  dp2ctl_t evt;

  sio_control i_control (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .txIrqClr(txIrqClr), .rxIrqClr(rxIrqClr),
    .txIrq(txIrq), .rxIrq(rxIrq), .cmd(cmd), .evt(evt)
  );

  sio_datapath #(.OVS(OVS)) i_datapath (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxdIn(rxd), .txdOut(txd),
    .cmd(cmd), .evt(evt)
  );
endmodule

// File: tb/test_sio_unit.sv
module test_sio_unit;
  localparam int OVS = 4;
  localparam logic [7:0] C_PAR = 8'h01, C_SEL = 8'h02, C_TX = 8'h10,
                         C_RX = 8'h20, C_SIO = 8'h80;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] addr = 2'd0;
  logic wrEn = 1'b0, rdEn = 1'b0, txIrqClr = 1'b0, rxIrqClr = 1'b0;
  logic [7:0] wrData = 8'h00, rdData;
  logic baudTick = 1'b1, rxdDrv = 1'b1, loop = 1'b0;
  logic txd, txIrq, rxIrq, rxd;
  int vectors = 0, miscompares = 0;

  assign rxd = loop ? txd : rxdDrv;

  always #4 clk = ~clk;

  sio_unit #(.OVS(OVS)) i_sio_unit (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .baudTick(baudTick), .rxd(rxd), .txd(txd),
    .txIrqClr(txIrqClr), .rxIrqClr(rxIrqClr), .txIrq(txIrq), .rxIrq(rxIrq)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdData;
  endtask

  task automatic readData(output logic [7:0] v);
    @(negedge clk); addr = 2'd0; rdEn = 1'b1; #1 v = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic pulseTxClr();
    @(negedge clk); txIrqClr = 1'b1; @(negedge clk); txIrqClr = 1'b0;
  endtask

  task automatic pulseRxClr();
    @(negedge clk); rxIrqClr = 1'b1; @(negedge clk); rxIrqClr = 1'b0;
  endtask

  task automatic waitStat(input int bitPos, input int limit);
    logic [7:0] s;
    for (int i = 0; i < limit; i++) begin
      peek(2'd2, s);
      if (s[bitPos]) break;
    end
  endtask

  task automatic captureTx(input int nBits, output logic [10:0] bits);
    bits = '0;
    for (int i = 0; i < 400 && txd !== 1'b0; i++) @(negedge clk);
    repeat (OVS / 2) @(negedge clk);
    bits[0] = txd;
    for (int i = 1; i < nBits; i++) begin
      repeat (OVS) @(negedge clk);
      bits[i] = txd;
    end
  endtask

  task automatic sendRx(input logic [7:0] b, input logic withPar, input logic parBit,
                        input logic stopBit);
    @(negedge clk); rxdDrv = 1'b0;
    repeat (OVS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxdDrv = b[i]; repeat (OVS) @(negedge clk);
    end
    if (withPar) begin rxdDrv = parBit; repeat (OVS) @(negedge clk); end
    rxdDrv = stopBit; repeat (OVS) @(negedge clk);
    rxdDrv = 1'b1; repeat (3 * OVS) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] s;
    peek(2'd2, s);
    chk("R1 status", s, 8'h00);
    chk("R1 irqs", {txIrq, rxIrq}, 2'b00);
    chk("R1 txd", txd, 1'b1);
  endtask

  task automatic testWriteWhileOff();
    logic [7:0] s;
    int lows = 0;
    busWrite(2'd0, 8'h55);
    for (int i = 0; i < 15 * OVS; i++) begin @(negedge clk); if (!txd) lows++; end
    chk("R11 no frame while disabled", lows, 0);
    peek(2'd2, s);
    chk("R11 tx empty stays 0", s[0], 1'b0);
  endtask

  task automatic testEnableEdge();
    logic [7:0] s;
    busWrite(2'd1, C_TX | C_SEL);
    peek(2'd2, s);
    chk("R2 flags on enable (sel=1)", s[1:0], 2'b11);
    chk("R2 tx irq on enable (sel=1)", txIrq, 1'b1);
    busWrite(2'd1, 8'h00);
    peek(2'd2, s);
    chk("R3 flags cleared on disable", s[1:0], 2'b00);
    pulseTxClr();
    chk("R10 clear drops request", txIrq, 1'b0);
    @(negedge clk); addr = 2'd1; wrData = C_TX; wrEn = 1'b1; txIrqClr = 1'b1;
    @(negedge clk); wrEn = 1'b0; txIrqClr = 1'b0;
    chk("R10 set wins over clear (R2 sel=0)", txIrq, 1'b1);
    pulseTxClr();
    repeat (20) @(negedge clk);
    chk("R10 stays clear without event", txIrq, 1'b0);
  endtask

  task automatic testFrames();
    logic [10:0] bits;
    logic [7:0] s;
    busWrite(2'd1, C_TX | C_PAR);
    pulseTxClr();
    busWrite(2'd0, 8'hA5);
    captureTx(11, bits);
    chk("R4 frame with parity", bits, {1'b1, ^8'hA5, 8'hA5, 1'b0});
    chk("R5 sel=0 irq on buffer empty", txIrq, 1'b1);
    repeat (OVS) @(negedge clk);
    peek(2'd2, s);
    chk("R5 flags after frame", s[1:0], 2'b11);
    busWrite(2'd1, C_TX);
    busWrite(2'd0, 8'h3C);
    captureTx(11, bits);
    chk("R4 frame without parity plus idle", bits, {1'b1, 1'b1, 8'h3C, 1'b0});
  endtask

  task automatic testSelShift();
    busWrite(2'd1, 8'h00);
    busWrite(2'd1, C_TX | C_SEL);
    pulseTxClr();
    busWrite(2'd0, 8'h0F);
    repeat (3) @(negedge clk);
    chk("R5 sel=1 no irq on load", txIrq, 1'b0);
    waitStat(1, 300);
    chk("R5 sel=1 irq at shift complete", txIrq, 1'b1);
  endtask

  task automatic testDisableMid();
    logic [7:0] s;
    int lows = 0;
    busWrite(2'd1, C_TX);
    busWrite(2'd0, 8'h81);
    busWrite(2'd0, 8'h42);
    repeat (6) @(negedge clk);
    busWrite(2'd1, 8'h00);
    @(negedge clk);
    chk("R3 txd idle after disable", txd, 1'b1);
    peek(2'd2, s);
    chk("R3 flags zero after disable", s[1:0], 2'b00);
    busWrite(2'd1, C_TX);
    peek(2'd2, s);
    chk("R2 flags set on re-enable", s[1:0], 2'b11);
    for (int i = 0; i < 15 * OVS; i++) begin @(negedge clk); if (!txd) lows++; end
    chk("R3 no leftover frame", lows, 0);
  endtask

  task automatic testLoopback();
    logic [7:0] s, v;
    loop = 1'b1;
    busWrite(2'd1, C_TX | C_RX | C_SIO | C_PAR);
    busWrite(2'd0, 8'h96);
    waitStat(2, 300);
    peek(2'd2, s);
    chk("R6 rx full", s[2], 1'b1);
    chk("R8 no errors on clean frame", s[5:3], 3'b000);
    chk("R6 rx irq", rxIrq, 1'b1);
    readData(v);
    chk("R6 received byte", v, 8'h96);
    peek(2'd2, s);
    chk("R6 read releases buffer", s[2], 1'b0);
    pulseRxClr();
    chk("R10 rx clear", rxIrq, 1'b0);
  endtask

  task automatic testOverrun();
    logic [7:0] s, v;
    busWrite(2'd1, C_TX | C_RX | C_SIO);
    busWrite(2'd0, 8'h11);
    busWrite(2'd0, 8'h22);
    repeat (30 * OVS) @(negedge clk);
    peek(2'd2, s);
    chk("R7 overrun flag", s[3:2], 2'b11);
    peek(2'd0, v);
    chk("R7 buffer keeps first byte", v, 8'h11);
  endtask

  task automatic testRxDisable();
    logic [7:0] s;
    busWrite(2'd1, C_TX | C_RX);
    peek(2'd2, s);
    chk("R9 port disable clears rx flags", s[5:2], 4'h0);
    loop = 1'b0; rxdDrv = 1'b1;
    busWrite(2'd1, C_RX | C_SIO);
    @(negedge clk); rxdDrv = 1'b0;
    repeat (4 * OVS) @(negedge clk);
    busWrite(2'd1, C_SIO);
    rxdDrv = 1'b1;
    busWrite(2'd1, C_RX | C_SIO);
    repeat (15 * OVS) @(negedge clk);
    peek(2'd2, s);
    chk("R9 partial frame discarded", s[2], 1'b0);
  endtask

  task automatic testErrors();
    logic [7:0] s, v;
    sendRx(8'h5A, 1'b0, 1'b0, 1'b0);
    peek(2'd2, s);
    chk("R8 framing error", {s[4], s[2]}, 2'b11);
    peek(2'd0, v);
    chk("R8 byte with framing error", v, 8'h5A);
    busWrite(2'd1, C_SIO);
    busWrite(2'd1, C_RX | C_SIO | C_PAR);
    sendRx(8'h01, 1'b1, 1'b0, 1'b1);
    peek(2'd2, s);
    chk("R8 parity error only", s[5:2], 4'b1001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWriteWhileOff();
    testEnableEdge();
    testFrames();
    testSelShift();
    testDisableMid();
    testLoopback();
    testOverrun();
    testRxDisable();
    testErrors();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule